// File: doc/BRIEF.md
# Miss-Aware Pseudo-LRU Victim Controller

This block holds the tree pseudo-LRU replacement state for every set of a set-associative data cache and names the victim way when an access misses. Each cycle it may take one access, which carries a set index, a line tag, a hit flag and the way that hit. Hits and misses both refresh the recency state of the addressed set, so that recently used ways are the last to be evicted.

A small table of outstanding misses records the set, tag and chosen victim of every line that has missed and is still waiting for its refill. If the same line misses again before the refill lands, the access is a secondary miss. It reuses the recorded victim and does not draw a fresh way from the tree, so the replacement order stays intact. A refill-done input carrying a table index releases the entry. A build parameter chooses whether secondary misses refresh the tree, since that update can be removed to ease timing.

When a new line misses and the table has no free entry, the block drops its ready output. The access then has no effect and has to be retried.

Top module: `plru_victim_ctrl`

## Requirements
- R1: After reset every tree bit is zero, so the first miss to any set picks way 0. No entry is pending, and acc_ready is high while no primary miss meets a full table.
- R2: An accepted hit marks the hit way as most recently used in its set. The tree has a root bit plus one bit per pair of ways. Root 0 selects ways 0–1 and root 1 selects ways 2–3; inside the pair, a bit of 0 selects the lower way. A touch points the root at the other half and the pair bit at the sibling way.
- R3: A miss whose set and tag match no pending entry is primary. miss_primary is high, victim_way is the way the tree selects, the tree is touched with that way, and a table entry records set, tag and way.
- R4: A miss that matches a pending entry is secondary. miss_secondary is high, victim_way is the recorded way, and no entry is allocated.
- R5: With TOUCH_ON_SECONDARY=1, a secondary miss touches the tree with the recorded way.
- R6: With TOUCH_ON_SECONDARY=0, a secondary miss leaves the tree unchanged.
- R7: A primary miss while all entries are valid drives acc_ready low. It neither allocates an entry nor touches the tree.
- R8: refill_valid with refill_idx invalidates that entry from the next cycle on. A miss to the same line in the refill cycle is still secondary.
- R9: A pending entry matches only when both its set and its tag are equal to the access.
- R10: A tree update is seen by the very next access. Sets are independent of each other.
- R11: A primary miss takes the lowest-numbered free entry, and that index is shown on alloc_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_tag | input | TAG_W | Line tag of the access |
| acc_hit | input | 1 | Access hit in the cache |
| acc_hit_way | input | WAY_W | Way that hit |
| acc_ready | output | 1 | Access accepted (low on a primary miss with a full table) |
| miss_primary | output | 1 | Access is a miss to a line with no pending refill |
| miss_secondary | output | 1 | Access is a miss to a line already pending |
| victim_way | output | WAY_W | Replacement way for the miss |
| alloc_idx | output | IDX_W | Table entry taken by an accepted primary miss |
| refill_valid | input | 1 | Refill finished for an entry |
| refill_idx | input | IDX_W | Entry whose refill finished |

## Verification
A corrupted tree bit in some set does not appear at the ports until the next miss to that set, where it shows up as a wrong victim_way. A bench therefore follows each touch with a miss to the same set in the next cycle. A lost or stale table entry shows up as the wrong miss class, either primary where secondary was expected or the reverse, or as a wrong alloc_idx on the next primary miss. Skipping or adding a secondary-miss touch only becomes visible at the next primary miss to that set. For that reason the bench runs both values of the parameter side by side and compares each against its own model.

// File: rtl/plru_ctrl_pkg.sv
package plru_ctrl_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_HIT  = 2'd1,
    ACC_PRIM = 2'd2,
    ACC_SEC  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/plru_tree_store.sv
// Per-set binary-tree recency bits; node n (1-based heap order) lives at bit n-1.
module plru_tree_store #(
  parameter int WAYS = 4,
  parameter int SETS = 64,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] sel_set,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);

  logic [NODES-1:0] tree_q [SETS];

  // Walk from the root, following each bit toward the older side.
  function automatic logic [WAY_W-1:0] walk_victim(input logic [NODES-1:0] t);
    int node;
    node = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      node = 2 * node + (t[node-1] ? 1 : 0);
    end
    return WAY_W'(node - WAYS);
  endfunction

  // Point every node on the path to way w away from it.
  function automatic logic [NODES-1:0] mark_used(input logic [NODES-1:0] t,
                                                 input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    int node;
    r    = t;
    node = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      r[node-1] = ~w[WAY_W-1-lvl];
      node = 2 * node + (w[WAY_W-1-lvl] ? 1 : 0);
    end
    return r;
  endfunction

  assign victim = walk_victim(tree_q[sel_set]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[sel_set] <= mark_used(tree_q[sel_set], touch_way);
    end
  end

endmodule

// File: rtl/pend_miss_table.sv
// Outstanding-miss entries: lookup by set+tag, lowest-free allocation, release by index.
module pend_miss_table #(
  parameter int ENTRIES = 4,
  parameter int SET_W   = 6,
  parameter int TAG_W   = 20,
  parameter int WAY_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SET_W-1:0]   lk_set,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_match,
  output logic [WAY_W-1:0]   lk_way,
  output logic               full,
  output logic [IDX_W-1:0]   free_idx,
  input  logic               alloc_en,
  input  logic [WAY_W-1:0]   alloc_way,
  input  logic               rel_en,
  input  logic [IDX_W-1:0]   rel_idx,
  output logic [ENTRIES-1:0] valid_o
);

  logic [ENTRIES-1:0] v_q;
  logic [SET_W-1:0]   set_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [WAY_W-1:0]   way_q [ENTRIES];
  logic [ENTRIES-1:0] cmp;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign cmp[e] = v_q[e] && (set_q[e] == lk_set) && (tag_q[e] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (cmp[e]) lk_way = lk_way | way_q[e];
    end
  end

  always_comb begin
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!v_q[e]) free_idx = IDX_W'(e);
    end
  end

  assign lk_match = |cmp;
  assign full     = &v_q;
  assign valid_o  = v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        set_q[e] <= '0;
        tag_q[e] <= '0;
        way_q[e] <= '0;
      end
    end else begin
      if (rel_en) v_q[rel_idx] <= 1'b0;
      if (alloc_en) begin
        v_q[free_idx]   <= 1'b1;
        set_q[free_idx] <= lk_set;
        tag_q[free_idx] <= lk_tag;
        way_q[free_idx] <= alloc_way;
      end
    end
  end

endmodule

// File: rtl/plru_victim_ctrl.sv
module plru_victim_ctrl
  import plru_ctrl_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int SETS    = 64,
  parameter int TAG_W   = 20,
  parameter int ENTRIES = 4,
  parameter bit TOUCH_ON_SECONDARY = 1'b1,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_hit_way,
  output logic             acc_ready,
  output logic             miss_primary,
  output logic             miss_secondary,
  output logic [WAY_W-1:0] victim_way,
  output logic [IDX_W-1:0] alloc_idx,
  input  logic             refill_valid,
  input  logic [IDX_W-1:0] refill_idx
);

  acc_kind_e          kind;
  logic               lookup_hit;
  logic [WAY_W-1:0]   lookup_way;
  logic [WAY_W-1:0]   tree_pick;
  logic               tbl_full;
  logic [IDX_W-1:0]   free_idx;
  logic [ENTRIES-1:0] pend_valid;
  logic               acc_fire;
  logic               alloc_en;
  logic               touch_en;
  logic [WAY_W-1:0]   touch_way;

  always_comb begin
    kind = ACC_IDLE;
    if (acc_valid) begin
      if (acc_hit)         kind = ACC_HIT;
      else if (lookup_hit) kind = ACC_SEC;
      else                 kind = ACC_PRIM;
    end
  end

  assign acc_ready = !((kind == ACC_PRIM) && tbl_full);
  assign acc_fire  = acc_valid && acc_ready;
  assign alloc_en  = acc_fire && (kind == ACC_PRIM);
  assign touch_en  = acc_fire && ((kind != ACC_SEC) || TOUCH_ON_SECONDARY);

  always_comb begin
    case (kind)
      ACC_HIT: touch_way = acc_hit_way;
      ACC_SEC: touch_way = lookup_way;
      default: touch_way = tree_pick;
    endcase
  end

  assign miss_primary   = (kind == ACC_PRIM);
  assign miss_secondary = (kind == ACC_SEC);
  assign victim_way     = (kind == ACC_SEC) ? lookup_way : tree_pick;
  assign alloc_idx      = free_idx;

  plru_tree_store #(.WAYS(WAYS), .SETS(SETS)) u_tree (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_set   (acc_set),
    .victim    (tree_pick),
    .touch_en  (touch_en),
    .touch_way (touch_way)
  );

  pend_miss_table #(
    .ENTRIES (ENTRIES),
    .SET_W   (SET_W),
    .TAG_W   (TAG_W),
    .WAY_W   (WAY_W)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (acc_set),
    .lk_tag    (acc_tag),
    .lk_match  (lookup_hit),
    .lk_way    (lookup_way),
    .full      (tbl_full),
    .free_idx  (free_idx),
    .alloc_en  (alloc_en),
    .alloc_way (tree_pick),
    .rel_en    (refill_valid),
    .rel_idx   (refill_idx),
    .valid_o   (pend_valid)
  );

endmodule

// File: rtl/plru_victim_chk.sv
module plru_victim_chk #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_hit,
  input logic               acc_ready,
  input logic               lookup_hit,
  input logic               tbl_full,
  input logic               alloc_en,
  input logic [IDX_W-1:0]   alloc_idx,
  input logic               touch_en,
  input logic               miss_primary,
  input logic               miss_secondary,
  input logic               refill_valid,
  input logic [IDX_W-1:0]   refill_idx,
  input logic [ENTRIES-1:0] pend_valid
);

  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_hit && !lookup_hit && tbl_full |-> !acc_ready);

  a_r7_no_touch_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |-> !touch_en && !alloc_en);

  a_r4_no_realloc: assert property (@(posedge clk) disable iff (!rst_n)
    miss_secondary |-> !alloc_en);

  a_r3_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_primary, miss_secondary}));

  a_r8_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid && !(alloc_en && (alloc_idx == refill_idx))
    |=> !pend_valid[$past(refill_idx)]);

  a_r11_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !pend_valid[alloc_idx]);

  a_r11_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> pend_valid[$past(alloc_idx)]);

endmodule

bind plru_victim_ctrl plru_victim_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_hit        (acc_hit),
  .acc_ready      (acc_ready),
  .lookup_hit     (lookup_hit),
  .tbl_full       (tbl_full),
  .alloc_en       (alloc_en),
  .alloc_idx      (alloc_idx),
  .touch_en       (touch_en),
  .miss_primary   (miss_primary),
  .miss_secondary (miss_secondary),
  .refill_valid   (refill_valid),
  .refill_idx     (refill_idx),
  .pend_valid     (pend_valid)
);

// File: tb/tb_plru_victim_ctrl.sv
module tb_plru_victim_ctrl;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        a_v, a_hit, rf_v;
  logic [1:0]  a_hw, rf_i;
  logic [5:0]  a_set;
  logic [19:0] a_tag;
  logic        o_rdy [2];
  logic        o_pri [2];
  logic        o_sec [2];
  logic [1:0]  o_vw  [2];
  logic [1:0]  o_ai  [2];

  plru_victim_ctrl #(.TOUCH_ON_SECONDARY(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(a_v), .acc_set(a_set), .acc_tag(a_tag),
    .acc_hit(a_hit), .acc_hit_way(a_hw), .acc_ready(o_rdy[0]),
    .miss_primary(o_pri[0]), .miss_secondary(o_sec[0]), .victim_way(o_vw[0]),
    .alloc_idx(o_ai[0]), .refill_valid(rf_v), .refill_idx(rf_i));

  plru_victim_ctrl #(.TOUCH_ON_SECONDARY(1'b0)) dut_noupd (
    .clk(clk), .rst_n(rst_n), .acc_valid(a_v), .acc_set(a_set), .acc_tag(a_tag),
    .acc_hit(a_hit), .acc_hit_way(a_hw), .acc_ready(o_rdy[1]),
    .miss_primary(o_pri[1]), .miss_secondary(o_sec[1]), .victim_way(o_vw[1]),
    .alloc_idx(o_ai[1]), .refill_valid(rf_v), .refill_idx(rf_i));

  int checks = 0;
  int errors = 0;

  // Bench model: bit0 root, bit1 lower pair, bit2 upper pair.
  logic [2:0]  mt  [2][64];
  bit          mv  [2][4];
  logic [5:0]  ms  [2][4];
  logic [19:0] mtg [2][4];
  logic [1:0]  mw  [2][4];

  function automatic logic [1:0] m_victim(input logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] m_touch(input logic [2:0] t, input logic [1:0] w);
    case (w)
      2'd0:    return {t[2], 1'b1, 1'b1};
      2'd1:    return {t[2], 1'b0, 1'b1};
      2'd2:    return {1'b1, t[1], 1'b0};
      default: return {1'b0, t[1], 1'b0};
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic access(input bit v, input bit hit, input logic [1:0] hw,
                        input logic [5:0] s, input logic [19:0] t,
                        input bit rv, input logic [1:0] ri, input string req);
    @(negedge clk);
    a_v = v; a_hit = hit; a_hw = hw; a_set = s; a_tag = t; rf_v = rv; rf_i = ri;
    #2;
    for (int k = 0; k < 2; k++) begin
      bit m, pri, sec, full, rdy;
      logic [1:0] mway, vic, fr;
      string lab;
      m = 0; mway = 0; full = 1; fr = 0;
      for (int e = 3; e >= 0; e--) begin
        if (mv[k][e] && ms[k][e] == s && mtg[k][e] == t) begin m = 1; mway = mw[k][e]; end
        if (!mv[k][e]) begin full = 0; fr = 2'(e); end
      end
      pri = v && !hit && !m;
      sec = v && !hit && m;
      rdy = !(pri && full);
      vic = sec ? mway : m_victim(mt[k][s]);
      lab = {req, (k == 0) ? " R5 dut" : " R6 dut_noupd"};
      chk(lab, "ready", int'(o_rdy[k]), int'(rdy));
      chk(lab, "primary", int'(o_pri[k]), int'(pri));
      chk(lab, "secondary", int'(o_sec[k]), int'(sec));
      if ((pri && rdy) || sec) chk(lab, "victim", int'(o_vw[k]), int'(vic));
      if (pri && rdy) chk({lab, " R11"}, "alloc_idx", int'(o_ai[k]), int'(fr));
      if (v && rdy) begin
        if (hit) mt[k][s] = m_touch(mt[k][s], hw);
        else if (pri) begin
          mt[k][s] = m_touch(mt[k][s], vic);
          mv[k][fr] = 1; ms[k][fr] = s; mtg[k][fr] = t; mw[k][fr] = vic;
        end else if (k == 0) mt[k][s] = m_touch(mt[k][s], vic);
      end
      if (rv) mv[k][ri] = 0;
    end
  endtask

  typedef struct packed {
    logic        hit;
    logic [1:0]  way;
    logic [5:0]  set;
    logic [19:0] tag;
    logic [1:0]  vict;
  } vec_t;

  localparam logic [19:0] TA = 20'h000A1, TB = 20'h000B2, TC = 20'h000C3,
                          TD = 20'h000D4, TE = 20'h000E5, TF = 20'h000F6;

  // Back-to-back accesses (R10); victims are the expected values for dut.
  localparam vec_t TBL [8] = '{
    '{1'b1, 2'd0, 6'd5, 20'h0, 2'd0},  // R2 hit way 0
    '{1'b0, 2'd0, 6'd5, TA,    2'd2},  // R3 primary
    '{1'b0, 2'd0, 6'd5, TA,    2'd2},  // R4 secondary
    '{1'b1, 2'd3, 6'd5, 20'h0, 2'd0},  // R2 hit way 3
    '{1'b0, 2'd0, 6'd5, TB,    2'd1},  // R3 primary
    '{1'b0, 2'd0, 6'd9, TA,    2'd0},  // R9 same tag, other set; R1 fresh set
    '{1'b0, 2'd0, 6'd5, TA,    2'd2},  // R4 secondary
    '{1'b0, 2'd0, 6'd5, TC,    2'd0}   // R3 primary, table now full
  };

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 64; s++) mt[k][s] = '0;
      for (int e = 0; e < 4; e++) begin mv[k][e] = 0; ms[k][e] = 0; mtg[k][e] = 0; mw[k][e] = 0; end
    end
    rst_n = 0; a_v = 0; a_hit = 0; a_hw = 0; a_set = 0; a_tag = 0; rf_v = 0; rf_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #2;
    for (int k = 0; k < 2; k++) begin
      chk("R1", "reset ready", int'(o_rdy[k]), 1);
      chk("R1", "reset primary", int'(o_pri[k]), 0);
      chk("R1", "reset secondary", int'(o_sec[k]), 0);
    end

    for (int i = 0; i < 8; i++) begin
      access(1'b1, TBL[i].hit, TBL[i].way, TBL[i].set, TBL[i].tag, 1'b0, 2'd0,
             TBL[i].hit ? "R2" : "R3/R4/R9");
      if (!TBL[i].hit) chk("R10 table", "dut victim", int'(o_vw[0]), int'(TBL[i].vict));
    end

    // R7: table full, new line stalls and changes nothing
    access(1'b1, 1'b0, 2'd0, 6'd5, TD, 1'b0, 2'd0, "R7");
    // R8: refill of entry 1 in the same cycle as a miss to its line
    access(1'b1, 1'b0, 2'd0, 6'd5, TB, 1'b1, 2'd1, "R8");
    // R8/R11: entry now free, line misses as primary into slot 1
    access(1'b1, 1'b0, 2'd0, 6'd5, TB, 1'b0, 2'd0, "R8");
    chk("R11", "alloc lowest free", int'(o_ai[0]), 1);
    for (int e = 0; e < 4; e++) access(1'b0, 1'b0, 2'd0, 6'd0, 20'h0, 1'b1, 2'(e), "R8 idle");

    // R5/R6: a secondary touch that changes the next victim
    access(1'b1, 1'b0, 2'd0, 6'd20, TE, 1'b0, 2'd0, "R1");
    access(1'b1, 1'b1, 2'd2, 6'd20, 20'h0, 1'b0, 2'd0, "R2");
    access(1'b1, 1'b0, 2'd0, 6'd20, TE, 1'b0, 2'd0, "R4");
    access(1'b1, 1'b0, 2'd0, 6'd20, TF, 1'b0, 2'd0, "R5/R6");
    chk("R5", "dut victim after touch", int'(o_vw[0]), 3);
    chk("R6", "noupd victim untouched", int'(o_vw[1]), 1);
    access(1'b0, 1'b0, 2'd0, 6'd0, 20'h0, 1'b0, 2'd0, "idle");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule